// File: doc/BRIEF.md
# Multi-Mode Register Load/Store Engine

This block moves 16-bit words between an eight-entry register file and a 256-word memory that it holds internally. A caller presents one request at a time: an operation code, a target register, a pointer register and a 16-bit constant. The engine resolves the effective address for the chosen operation, performs one write or up to two chained memory reads, updates the register file and then pulses `done` for a single cycle.

Seven operation codes are defined. One loads the constant into a register. The others load from a memory address taken from the constant, from a pointer register, or from a pointer register plus the constant. One variant also advances the pointer register after its load, so that a run of requests can walk through an array. Another variant reads a pointer out of memory before it loads. The last one stores a register to an address taken from the constant. The eighth code is rejected. Only the low eight bits of any computed address reach the memory, so all address arithmetic wraps at 256 words. A combinational read port lets the caller see any register.

Top module: `ldst_unit`

## Requirements
- R1: Code 0 (constant load) writes `reqConst` into register `reqReg` without touching memory. Every register, register 0 included, is writable.
- R2: Code 1 (absolute load) writes the memory word at address `reqConst[7:0]` into register `reqReg`.
- R3: Code 2 (absolute store) writes the contents of register `reqReg` into memory at `reqConst[7:0]`. No register changes.
- R4: Code 3 (pointer load) writes the memory word addressed by the low 8 bits of register `reqPtr` into register `reqReg`.
- R5: Code 4 (pointer load with step) loads the same way as code 3 and then adds one to register `reqPtr`, modulo 2^16.
- R6: Code 5 (offset load) loads from address (register `reqPtr` + `reqConst`) mod 256.
- R7: Code 6 (double-fetch load) reads the word at `reqConst[7:0]`, uses its low 8 bits as a second address and writes the word found there into register `reqReg`.
- R8: After reset `busy`, `done` and `errFlag` are low and every register reads zero.
- R9: Counting from the clock edge that accepts a request, `done` rises for exactly one cycle after 2 edges for codes 0, 2 and 7, after 3 edges for codes 1, 3, 4 and 5, and after 4 edges for code 6. `busy` is high from acceptance until `done`.
- R10: A request is accepted only while `busy` is low. A `reqValid` seen while busy has no effect.
- R11: Address arithmetic wraps at the memory size. Bits above bit 7 of the constant, of the pointer and of the fetched pointer are ignored.
- R12: Code 7 is illegal. It completes after 2 edges with `errFlag` high together with `done` and changes no register or memory word. `errFlag` stays low for every legal code.
- R13: When code 4 names the same register as target and pointer, the loaded word is written and no increment takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqMode | input | 3 | Operation code 0..7 |
| reqReg | input | 3 | Target register (source register for a store) |
| reqPtr | input | 3 | Pointer register for codes 3, 4 and 5 |
| reqConst | input | 16 | Constant field |
| rdSel | input | 3 | Register select for the observation port |
| rdData | output | 16 | Contents of register `rdSel` |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | High with `done` when the code was illegal |

## Verification
On every cycle the assertions check the handshake timing: each operation code finishes with a single `done` pulse at its fixed distance from acceptance, `busy` and `done` never overlap, and `errFlag` appears only with `done` and only for code 7. The data results can only be shown by the bench scenarios. These include the loaded words, the pointer step and its priority when target and pointer are the same register, address wrap, stores read back through later loads, and the fact that illegal or busy-time requests leave state unchanged. The bench runs all of these against a reference model of the register file and the memory.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [2:0] {
    OP_CONST   = 3'd0,
    OP_ABS     = 3'd1,
    OP_STORE   = 3'd2,
    OP_PTR     = 3'd3,
    OP_PTRSTEP = 3'd4,
    OP_OFFSET  = 3'd5,
    OP_DOUBLE  = 3'd6,
    OP_BAD     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ADDR_CONST,
    ADDR_PTR,
    ADDR_OFFSET,
    ADDR_FETCHED
  } addr_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_READ1,
    ST_READ2
  } seq_state_e;

  typedef struct packed {
    logic      capture;
    addr_sel_e addrSel;
    logic      memRd;
    logic      memWr;
    logic      regWr;
    logic      regFromMem;
    logic      ptrStep;
  } strobe_t;

endpackage

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int MEM_DEPTH = 256
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     ctl,
  input  logic [$clog2(NUM_REGS)-1:0] reqReg,
  input  logic [$clog2(NUM_REGS)-1:0] reqPtr,
  input  logic [DATA_W-1:0]           reqConst,
  input  logic [$clog2(NUM_REGS)-1:0] rdSel,
  output logic [DATA_W-1:0]           rdData
);

  localparam int REG_AW = $clog2(NUM_REGS);
  localparam int ADDR_W = $clog2(MEM_DEPTH);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]               mem [MEM_DEPTH];
  logic [DATA_W-1:0]               memQ;

  logic [REG_AW-1:0] dstQ;
  logic [REG_AW-1:0] ptrQ;
  logic [DATA_W-1:0] constQ;

  logic [DATA_W-1:0] ptrVal;
  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] offsetSum;
  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] wrData;

  // Request fields are held for the whole sequence
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstQ   <= '0;
      ptrQ   <= '0;
      constQ <= '0;
    end else if (ctl.capture) begin
      dstQ   <= reqReg;
      ptrQ   <= reqPtr;
      constQ <= reqConst;
    end
  end

  assign ptrVal    = regs[ptrQ];
  assign srcVal    = regs[dstQ];
  assign offsetSum = ptrVal + constQ;

  always_comb begin
    case (ctl.addrSel)
      ADDR_PTR:     effAddr = ptrVal[ADDR_W-1:0];
      ADDR_OFFSET:  effAddr = offsetSum[ADDR_W-1:0];
      ADDR_FETCHED: effAddr = memQ[ADDR_W-1:0];
      default:      effAddr = constQ[ADDR_W-1:0];
    endcase
  end

  // Single-port synchronous memory, registered read data
  always_ff @(posedge clk) begin
    if (ctl.memWr) begin
      mem[effAddr] <= srcVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memQ <= '0;
    end else if (ctl.memRd) begin
      memQ <= mem[effAddr];
    end
  end

  assign wrData = ctl.regFromMem ? memQ : constQ;

  // One register slice per entry; a data write beats the pointer step
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regs[gi] <= '0;
      end else if (ctl.regWr && (dstQ == REG_AW'(gi))) begin
        regs[gi] <= wrData;
      end else if (ctl.ptrStep && (ptrQ == REG_AW'(gi))) begin
        regs[gi] <= regs[gi] + DATA_W'(1);
      end
    end
  end

  assign rdData = regs[rdSel];

endmodule

// File: rtl/ldst_control.sv
module ldst_control
  import ldst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqMode,
  output strobe_t    ctl,
  output logic       busy,
  output logic       done,
  output logic       errFlag
);

  seq_state_e state, stateNext;
  op_e        opQ;
  logic       finish;
  logic       illegal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= OP_CONST;
    end else if (ctl.capture) begin
      opQ <= op_e'(reqMode);
    end
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    finish    = 1'b0;
    illegal   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capture = 1'b1;
          stateNext   = ST_EXEC;
        end
      end
      ST_EXEC: begin
        case (opQ)
          OP_CONST: begin
            ctl.regWr = 1'b1;
            finish    = 1'b1;
          end
          OP_STORE: begin
            ctl.memWr   = 1'b1;
            ctl.addrSel = ADDR_CONST;
            finish      = 1'b1;
          end
          OP_ABS, OP_DOUBLE: begin
            ctl.memRd   = 1'b1;
            ctl.addrSel = ADDR_CONST;
            stateNext   = ST_READ1;
          end
          OP_PTR, OP_PTRSTEP: begin
            ctl.memRd   = 1'b1;
            ctl.addrSel = ADDR_PTR;
            stateNext   = ST_READ1;
          end
          OP_OFFSET: begin
            ctl.memRd   = 1'b1;
            ctl.addrSel = ADDR_OFFSET;
            stateNext   = ST_READ1;
          end
          default: begin
            illegal = 1'b1;
            finish  = 1'b1;
          end
        endcase
      end
      ST_READ1: begin
        if (opQ == OP_DOUBLE) begin
          ctl.memRd   = 1'b1;
          ctl.addrSel = ADDR_FETCHED;
          stateNext   = ST_READ2;
        end else begin
          ctl.regWr      = 1'b1;
          ctl.regFromMem = 1'b1;
          ctl.ptrStep    = (opQ == OP_PTRSTEP);
          finish         = 1'b1;
        end
      end
      ST_READ2: begin
        ctl.regWr      = 1'b1;
        ctl.regFromMem = 1'b1;
        finish         = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
    if (finish) begin
      stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state   <= stateNext;
      done    <= finish;
      errFlag <= illegal;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int MEM_DEPTH = 256
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [2:0]                  reqMode,
  input  logic [$clog2(NUM_REGS)-1:0] reqReg,
  input  logic [$clog2(NUM_REGS)-1:0] reqPtr,
  input  logic [DATA_W-1:0]           reqConst,
  input  logic [$clog2(NUM_REGS)-1:0] rdSel,
  output logic [DATA_W-1:0]           rdData,
  output logic                        busy,
  output logic                        done,
  output logic                        errFlag
);

  strobe_t ctl;

  ldst_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done),
    .errFlag  (errFlag)
  );

  ldst_datapath #(
    .DATA_W    (DATA_W),
    .NUM_REGS  (NUM_REGS),
    .MEM_DEPTH (MEM_DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqReg   (reqReg),
    .reqPtr   (reqPtr),
    .reqConst (reqConst),
    .rdSel    (rdSel),
    .rdData   (rdData)
  );

endmodule

// File: rtl/ldst_unit_checker.sv
module ldst_unit_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [2:0] reqMode,
  input logic       busy,
  input logic       done,
  input logic       errFlag
);

  logic take;
  assign take = reqValid && !busy;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    take |=> busy);  // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> done);  // R12
  AST_LAT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (take && (reqMode == 3'd0 || reqMode == 3'd2)) |-> ##2 (done && !errFlag));  // R9
  AST_LAT_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (take && (reqMode == 3'd1 || reqMode == 3'd3 || reqMode == 3'd4 || reqMode == 3'd5))
      |-> ##3 (done && !errFlag));  // R9
  AST_LAT_TWO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (take && reqMode == 3'd6) |-> ##4 (done && !errFlag));  // R7
  AST_ILLEGAL_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (take && reqMode == 3'd7) |-> ##2 (done && errFlag));  // R12

endmodule

bind ldst_unit ldst_unit_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqMode  (reqMode),
  .busy     (busy),
  .done     (done),
  .errFlag  (errFlag)
);

// File: tb/ldst_unit_tb_top.sv
module ldst_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqMode = '0;
  logic [2:0]  reqReg = '0;
  logic [2:0]  reqPtr = '0;
  logic [15:0] reqConst = '0;
  logic [2:0]  rdSel = '0;
  logic [15:0] rdData;
  logic        busy, done, errFlag;

  int total = 0;
  int bad = 0;

  logic [15:0] mRegs [8];
  logic [15:0] mMem  [256];

  always #2.5 clk = ~clk;

  ldst_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqReg(reqReg), .reqPtr(reqPtr), .reqConst(reqConst),
    .rdSel(rdSel), .rdData(rdData), .busy(busy), .done(done), .errFlag(errFlag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expLatency(input logic [2:0] m);
    case (m)
      3'd0, 3'd2, 3'd7: return 2;
      3'd6:             return 4;
      default:          return 3;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic modelStep(input logic [2:0] m, input logic [2:0] d, input logic [2:0] p,
                           input logic [15:0] c);
    logic [15:0] v;
    logic [15:0] s;
    case (m)
      3'd0: mRegs[d] = c;
      3'd1: mRegs[d] = mMem[c[7:0]];
      3'd2: mMem[c[7:0]] = mRegs[d];
      3'd3: mRegs[d] = mMem[mRegs[p][7:0]];
      3'd4: begin
        v = mMem[mRegs[p][7:0]];
        if (d != p) mRegs[p] = mRegs[p] + 16'd1;
        mRegs[d] = v;
      end
      3'd5: begin
        s = mRegs[p] + c;
        mRegs[d] = mMem[s[7:0]];
      end
      3'd6: begin
        v = mMem[c[7:0]];
        mRegs[d] = mMem[v[7:0]];
      end
      default: ;
    endcase
  endtask

  task automatic checkRegs(input string tag);
    for (int i = 0; i < 8; i++) begin
      rdSel = 3'(i);
      #0.5;
      check(tag, {16'd0, rdData}, {16'd0, mRegs[i]});
    end
  endtask

  // Issue one request; optionally try a second request while busy (R10)
  task automatic runReq(input logic [2:0] m, input logic [2:0] d, input logic [2:0] p,
                        input logic [15:0] c, input bit intrude, input bit fullCheck);
    int lat;
    string tag;
    tag = tagOf(m);
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqReg = d; reqPtr = p; reqConst = c;
    @(negedge clk);
    if (intrude) begin
      reqMode = 3'd0; reqReg = 3'd7; reqConst = 16'hBEEF;
    end else begin
      reqValid = 1'b0;
    end
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      reqValid = 1'b0;
      lat++;
    end
    modelStep(m, d, p, c);
    if (fullCheck) begin
      check({tag, " R9 latency"}, 32'(lat), 32'(expLatency(m)));
      check({tag, " R12 err"}, {31'd0, errFlag}, {31'd0, (m == 3'd7)});
      checkRegs(intrude ? "R10 busy request ignored" : tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] m;
    for (int i = 0; i < 8; i++) mRegs[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    check("R8 busy", {31'd0, busy}, 32'd0);
    check("R8 done", {31'd0, done}, 32'd0);
    check("R8 err", {31'd0, errFlag}, 32'd0);
    checkRegs("R8 regs");

    // Fill memory with known contents through stores (R3, R1 incl. register 0)
    for (int a = 0; a < 256; a++) begin
      logic [15:0] w;
      w = 16'($urandom);
      runReq(3'd0, 3'd0, 3'd0, w, 1'b0, 1'b0);
      runReq(3'd2, 3'd0, 3'd0, 16'(a) | 16'hA500, 1'b0, 1'b0);
    end
    checkRegs("R1 register 0 write");

    // Directed: constant, absolute, store readback
    runReq(3'd0, 3'd3, 3'd0, 16'h1234, 1'b0, 1'b1);           // R1
    runReq(3'd2, 3'd3, 3'd0, 16'h0040, 1'b0, 1'b1);           // R3
    runReq(3'd1, 3'd5, 3'd0, 16'hFF40, 1'b0, 1'b1);           // R2, R11 high bits ignored
    check("R3 store readback", {16'd0, mRegs[5]}, 32'h1234);
    // Pointer with wrap of high bits (R11)
    runReq(3'd0, 3'd2, 3'd0, 16'h01FE, 1'b0, 1'b1);
    runReq(3'd3, 3'd4, 3'd2, 16'h0000, 1'b0, 1'b1);           // R4
    // Stepping through an array (R5)
    for (int k = 0; k < 4; k++) runReq(3'd4, 3'd6, 3'd2, 16'h0000, 1'b0, 1'b1);
    check("R5 pointer advanced", {16'd0, mRegs[2]}, 32'h0202);
    // Same target and pointer (R13)
    runReq(3'd0, 3'd1, 3'd0, 16'h0010, 1'b0, 1'b1);
    runReq(3'd4, 3'd1, 3'd1, 16'h0000, 1'b0, 1'b1);
    checkRegs("R13 no step when target equals pointer");
    // Offset with wrap (R6, R11)
    runReq(3'd0, 3'd2, 3'd0, 16'h00F0, 1'b0, 1'b1);
    runReq(3'd5, 3'd7, 3'd2, 16'h0020, 1'b0, 1'b1);
    // Double fetch (R7)
    runReq(3'd0, 3'd0, 3'd0, 16'h3377, 1'b0, 1'b1);
    runReq(3'd2, 3'd0, 3'd0, 16'h0011, 1'b0, 1'b1);
    runReq(3'd6, 3'd4, 3'd0, 16'h0011, 1'b0, 1'b1);
    check("R7 second address", {16'd0, mRegs[4]}, {16'd0, mMem[8'h77]});
    // Illegal code (R12) and busy-time request (R10)
    runReq(3'd7, 3'd3, 3'd2, 16'hFFFF, 1'b0, 1'b1);
    runReq(3'd1, 3'd5, 3'd0, 16'h0033, 1'b1, 1'b1);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      m = 3'($urandom_range(0, 7));
      runReq(m, 3'($urandom), 3'($urandom), 16'($urandom), 1'b0, 1'b1);
    end
    // Read back part of memory through absolute loads (R3, R2)
    for (int a = 0; a < 256; a += 17) runReq(3'd1, 3'd1, 3'd0, 16'(a), 1'b0, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule